// File: doc/BRIEF.md
# Rewindable FIFO with Strap-Selected Flag Style

This block is a single-clock FIFO with its own storage, 18 bits wide and of parameterized depth. Words go in on a write enable and come out through a registered data output. A mode strap, captured while the master reset is held, picks one of two flag styles. In standard mode, a read enable moves each word onto the output. In fall-through mode, the head word moves onto the output by itself and a read enable consumes it. Both resets are asynchronous and active low. The partial reset clears the contents but keeps the flag style that was latched.

The rewind function returns the read pointer to storage location zero. Everything written since the last reset can then be read again. A rewind starts a setup phase of a fixed number of cycles. During that phase the read-side flag shows "nothing to read", and both reads and writes are refused. A half-full flag reports occupancy above half the depth.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrst_n` is low, `mode_strap` is latched (0 = standard, 1 = fall-through). Both pointers go to location 0, `dout` clears to zero and `half_n` is 1. Standard mode shows `rd_flag`=0 and `wr_flag`=1. Fall-through mode shows `rd_flag`=1 and `wr_flag`=0.
- R2: While `prst_n` is low, pointers, contents and `dout` reset as in R1, but the latched mode does not change. The flags take the R1 reset levels of that kept mode.
- R3: In standard mode, a write with `wr_en`=1 stores `din` at the clock edge. A read with `rd_en`=1 places the oldest stored word on `dout` at that edge. Words leave in the order they were written.
- R4: In standard mode, `rd_flag` is 0 exactly when no word is stored or a rewind setup is running. `wr_flag` is 0 exactly when DEPTH words are stored.
- R5: In fall-through mode, the head word is loaded onto `dout` without a read enable, one edge after the edge that wrote it into empty storage. `rd_flag` falls to 0 at that same edge. A read with `rd_en`=1 consumes the word on `dout`, and the next word replaces it at that edge. When no word remains, `rd_flag` returns to 1.
- R6: In fall-through mode, `wr_flag` is 1 exactly when DEPTH words are held, counting the word on `dout`.
- R7: `half_n` is 0 exactly when more than DEPTH/2 words are held.
- R8: A write while full and a read while empty are ignored. Stored data, pointers and `dout` do not change.
- R9: `rt_req`=1 at an edge where `wr_en`=0 and `rd_en`=0 starts a rewind, but only if between 1 and DEPTH-2 writes were accepted since the last reset. Otherwise the request is ignored.
- R10: A rewind sets the read pointer to location 0 and runs a setup phase of SETUP_CYC edges after the request edge. During setup, reads and writes are ignored. In standard mode, `rd_flag` is 0 during setup and returns to 1 at the SETUP_CYC-th edge after the request. Reads then start again from location 0.
- R11: In fall-through mode, `rd_flag` is 1 during setup. One edge after setup ends, the word from location 0 appears on `dout` and `rd_flag` falls to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| mrst_n | input | 1 | Asynchronous master reset, active low; latches the mode strap |
| prst_n | input | 1 | Asynchronous partial reset, active low; keeps the mode |
| mode_strap | input | 1 | Flag style captured at master reset: 0 standard, 1 fall-through |
| wr_en | input | 1 | Write enable, active high |
| rd_en | input | 1 | Read enable, active high |
| rt_req | input | 1 | Rewind request, active high |
| din | input | 18 | Write data |
| dout | output | 18 | Registered read data |
| rd_flag | output | 1 | Standard: 0 = empty. Fall-through: 0 = word ready on dout |
| wr_flag | output | 1 | Standard: 0 = full. Fall-through: 1 = full |
| half_n | output | 1 | 0 when more than DEPTH/2 words are held |

## Verification
Outputs settle relative to clock edges as follows:
- Flag and `half_n` changes from a write, read or rewind appear just after the edge that accepts the operation.
- In standard mode, a read shows its word on `dout` after that same edge.
- In fall-through mode, the first word needs one more edge after its write.
- After a rewind, the read-side flag is held for SETUP_CYC edges. In fall-through mode, the word from location 0 shows one edge after that.

The bench drives inputs just after each falling edge and samples just before the next falling edge. Every expected value is placed on the edge count listed above. The bench sweeps the fill and drain of the whole depth in both modes.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  localparam int DATA_W = 18;

  // wrap a storage pointer for any depth
  function automatic int ptr_next(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // rewind allowed only for 1 .. depth-2 accepted writes
  function automatic logic rt_window_ok(int wrote, int depth);
    return (wrote >= 1) && (wrote <= depth - 2);
  endfunction

  // occupancy above half the depth
  function automatic logic over_half(int held, int depth);
    return held > (depth / 2);
  endfunction

endpackage

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
  parameter int DW    = 18,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DW        = 18,
  parameter int DEPTH     = 16,
  parameter int SETUP_CYC = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1,
  localparam int SW       = $clog2(SETUP_CYC + 1)
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_strap,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rt_req,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [AW-1:0] ram_raddr,
  output logic [DW-1:0] dout,
  output logic          fwft,
  output logic          in_setup,
  output logic          full,
  output logic          out_valid,
  output logic [CW-1:0] total_cnt
);
  import fifo_rt_pkg::*;

  logic          rst_n;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] ram_cnt, wr_total;
  logic [SW-1:0] setup_cnt;
  logic          fwft_q, out_valid_q;
  logic [DW-1:0] dout_q;

  // named internal events
  logic wr_fire, rt_fire, pop, std_take, fw_load, ram_take;

  assign rst_n     = mrst_n & prst_n;
  assign in_setup  = (setup_cnt != '0);
  assign total_cnt = ram_cnt + CW'(out_valid_q);
  assign full      = (total_cnt == CW'(DEPTH));

  assign wr_fire  = wr_en && !full && !in_setup;
  assign rt_fire  = rt_req && !wr_en && !rd_en && !in_setup &&
                    rt_window_ok(int'(wr_total), DEPTH);
  assign pop      = fwft_q && rd_en && out_valid_q && !in_setup;
  assign std_take = !fwft_q && rd_en && (ram_cnt != '0) && !in_setup;
  assign fw_load  = fwft_q && !in_setup && (ram_cnt != '0) && (!out_valid_q || pop);
  assign ram_take = (std_take || fw_load) && !rt_fire;

  // mode is only touched by the master reset
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) fwft_q <= mode_strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr        <= '0;
      rptr        <= '0;
      ram_cnt     <= '0;
      wr_total    <= '0;
      setup_cnt   <= '0;
      out_valid_q <= 1'b0;
      dout_q      <= '0;
    end else if (rt_fire) begin
      rptr        <= '0;
      ram_cnt     <= wr_total;
      out_valid_q <= 1'b0;
      setup_cnt   <= SW'(SETUP_CYC);
    end else begin
      if (in_setup) setup_cnt <= setup_cnt - 1'b1;
      if (wr_fire) begin
        wptr <= AW'(ptr_next(int'(wptr), DEPTH));
        if (wr_total != CW'(DEPTH)) wr_total <= wr_total + 1'b1;
      end
      if (ram_take) begin
        rptr   <= AW'(ptr_next(int'(rptr), DEPTH));
        dout_q <= ram_rdata;
      end
      ram_cnt <= ram_cnt + CW'(wr_fire) - CW'(ram_take);
      if (fw_load)  out_valid_q <= 1'b1;
      else if (pop) out_valid_q <= 1'b0;
    end
  end

  assign ram_we    = wr_fire;
  assign ram_waddr = wptr;
  assign ram_raddr = rptr;
  assign dout      = dout_q;
  assign fwft      = fwft_q;
  assign out_valid = out_valid_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total_cnt <= CW'(DEPTH));

  // R8
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en) |=> (wptr == $past(wptr)));

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft_q && ram_cnt == '0 && rd_en) |=> (rptr == $past(rptr) && dout_q == $past(dout_q)));

  // R9
  rewind_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_fire |=> (rptr == '0 && in_setup));

  // R10
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_setup |=> (wptr == $past(wptr)));

  // R5
  fwft_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_q |-> fwft_q);

endmodule

// File: rtl/fifo_rt_flags.sv
module fifo_rt_flags #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          fwft,
  input  logic          in_setup,
  input  logic          full,
  input  logic          out_valid,
  input  logic [CW-1:0] total_cnt,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_n
);
  import fifo_rt_pkg::*;

  logic std_empty;

  assign std_empty = (total_cnt == '0) || in_setup;

  always_comb begin
    if (fwft) begin
      rd_flag = !out_valid || in_setup;  // 1 = not ready
      wr_flag = full;                    // 1 = full
    end else begin
      rd_flag = !std_empty;              // 0 = empty
      wr_flag = !full;                   // 0 = full
    end
  end

  assign half_n = !over_half(int'(total_cnt), DEPTH);

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int DEPTH     = 16,
  parameter int SETUP_CYC = 4,
  localparam int DW       = fifo_rt_pkg::DATA_W,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_strap,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rt_req,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          half_n
);

  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [DW-1:0] ram_rdata;
  logic          fwft, in_setup, full, out_valid;
  logic [CW-1:0] total_cnt;

  fifo_rt_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(din),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  fifo_rt_ctrl #(.DW(DW), .DEPTH(DEPTH), .SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_strap(mode_strap),
    .wr_en(wr_en), .rd_en(rd_en), .rt_req(rt_req), .ram_rdata(ram_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_raddr(ram_raddr),
    .dout(dout), .fwft(fwft), .in_setup(in_setup), .full(full),
    .out_valid(out_valid), .total_cnt(total_cnt)
  );

  fifo_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .fwft(fwft), .in_setup(in_setup), .full(full), .out_valid(out_valid),
    .total_cnt(total_cnt), .rd_flag(rd_flag), .wr_flag(wr_flag), .half_n(half_n)
  );

  // R7
  half_flag_chk: assert property (@(posedge clk) disable iff (!(mrst_n && prst_n))
    (!half_n && !fwft && !in_setup) |-> rd_flag);

endmodule

// File: tb/rewind_fifo_bench.sv
`timescale 1ns/1ps
module rewind_fifo_bench;
  localparam int DEPTH = 16;
  localparam int SETUP = 4;

  logic        clk = 1'b0;
  logic        mrst_n = 1'b0, prst_n = 1'b1, mode_strap = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rt_req = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        rd_flag, wr_flag, half_n;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  rewind_fifo #(.DEPTH(DEPTH), .SETUP_CYC(SETUP)) u_rewind_fifo (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_strap(mode_strap),
    .wr_en(wr_en), .rd_en(rd_en), .rt_req(rt_req), .din(din),
    .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag), .half_n(half_n)
  );

  function automatic logic [17:0] pat(int s, int i);
    return 18'((s * 7919 + i * 1237 + 3) & 18'h3FFFF);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    // ---- R1 master reset, standard strap
    tick(); tick();
    chk("R1 std rd_flag", rd_flag, 0); chk("R1 std wr_flag", wr_flag, 1);
    chk("R1 half_n", half_n, 1);       chk("R1 dout", dout, 0);
    mrst_n = 1'b1; tick();

    // ---- R3 R4 R7 standard fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1; din = pat(1, i); tick();
      chk("R4 rd_flag after write", rd_flag, 1);
      chk("R4 wr_flag fill", wr_flag, (i + 1 < DEPTH) ? 1 : 0);
      chk("R7 half_n fill", half_n, (i + 1 > DEPTH / 2) ? 0 : 1);
    end
    din = 18'h3FFFF; tick();                       // R8 write while full
    wr_en = 0; chk("R8 still full", wr_flag, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1; tick();
      chk("R3 read order", dout, pat(1, i));
      chk("R7 half_n drain", half_n, (DEPTH - 1 - i > DEPTH / 2) ? 0 : 1);
    end
    chk("R4 empty after drain", rd_flag, 0);
    tick();                                        // R8 read while empty
    rd_en = 0;
    chk("R8 dout kept on empty read", dout, pat(1, DEPTH - 1));
    wr_en = 1; din = pat(2, 0); tick(); wr_en = 0;
    rd_en = 1; tick(); rd_en = 0;
    chk("R8 rptr unmoved by empty read", dout, pat(2, 0));

    // ---- R9 rewind ignored after too many writes
    wr_en = 1; din = pat(2, 1); tick(); wr_en = 0;
    rt_req = 1; tick(); rt_req = 0;
    chk("R9 ignored rewind", rd_flag, 1);
    rd_en = 1; tick(); rd_en = 0;
    chk("R9 data after ignored rewind", dout, pat(2, 1));

    // ---- R2 partial reset keeps standard mode
    prst_n = 0; tick(); tick();
    chk("R2 std rd_flag", rd_flag, 0); chk("R2 std wr_flag", wr_flag, 1);
    chk("R2 half_n", half_n, 1);       chk("R2 dout", dout, 0);
    prst_n = 1; tick();

    // ---- R10 standard rewind
    for (int i = 0; i < 5; i++) begin wr_en = 1; din = pat(3, i); tick(); end
    wr_en = 0;
    for (int i = 0; i < 2; i++) begin
      rd_en = 1; tick(); chk("R3 pre-rewind read", dout, pat(3, i));
    end
    rd_en = 0; rt_req = 1; tick(); rt_req = 0;
    chk("R10 setup empty", rd_flag, 0);
    wr_en = 1; din = 18'h15555;
    for (int i = 0; i < SETUP - 1; i++) begin
      tick(); chk("R10 setup empty held", rd_flag, 0);
    end
    wr_en = 0; tick();
    chk("R10 setup done", rd_flag, 1);
    for (int i = 0; i < 5; i++) begin
      rd_en = 1; tick(); chk("R10 replay from location 0", dout, pat(3, i));
    end
    rd_en = 0;
    chk("R10 setup writes ignored", rd_flag, 0);

    // ---- R1 master reset into fall-through
    mode_strap = 1; mrst_n = 0; tick(); tick();
    chk("R1 ft rd_flag", rd_flag, 1); chk("R1 ft wr_flag", wr_flag, 0);
    chk("R1 ft half_n", half_n, 1);   chk("R1 ft dout", dout, 0);
    mrst_n = 1; mode_strap = 0; tick();

    // ---- R5 R6 R7 fall-through fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      wr_en = 1; din = pat(4, i); tick();
      if (i == 0) chk("R5 not ready yet", rd_flag, 1);
      if (i == 1) begin
        chk("R5 first word ready", rd_flag, 0);
        chk("R5 first word falls through", dout, pat(4, 0));
      end
      chk("R6 wr_flag fill", wr_flag, (i + 1 == DEPTH) ? 1 : 0);
      chk("R7 ft half_n", half_n, (i + 1 > DEPTH / 2) ? 0 : 1);
    end
    din = 18'h2AAAA; tick(); wr_en = 0;              // R8 write while full
    chk("R6 full held", wr_flag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd_en = 1; tick();
      if (i < DEPTH - 1) chk("R5 pop next word", dout, pat(4, i + 1));
      else               chk("R5 drained", rd_flag, 1);
    end
    rd_en = 0;

    // ---- R2 partial reset keeps fall-through
    prst_n = 0; tick(); tick();
    chk("R2 ft rd_flag", rd_flag, 1); chk("R2 ft wr_flag", wr_flag, 0);
    chk("R2 ft dout", dout, 0);
    prst_n = 1; tick();

    // ---- R9 rewind ignored with nothing written since reset
    rt_req = 1; tick(); rt_req = 0;
    wr_en = 1; din = pat(5, 0); tick(); wr_en = 0; tick();
    chk("R9 no setup after zero writes", rd_flag, 0);
    chk("R9 word passed", dout, pat(5, 0));
    rd_en = 1; tick(); rd_en = 0;
    chk("R5 emptied", rd_flag, 1);

    // ---- R11 fall-through rewind
    for (int i = 0; i < 3; i++) begin wr_en = 1; din = pat(6, i); tick(); end
    wr_en = 0; tick();
    rd_en = 1; tick(); rd_en = 0;
    chk("R5 second word", dout, pat(6, 1));
    rt_req = 1; tick(); rt_req = 0;
    chk("R11 setup not ready", rd_flag, 1);
    for (int i = 0; i < SETUP; i++) begin
      tick(); chk("R11 not ready held", rd_flag, 1);
    end
    tick();
    chk("R11 ready after setup", rd_flag, 0);
    chk("R11 location 0 word", dout, pat(5, 0));
    for (int i = 0; i < 3; i++) begin
      rd_en = 1; tick(); chk("R11 replay order", dout, pat(6, i));
    end
    tick(); rd_en = 0;
    chk("R11 replay end", rd_flag, 1);

    report();
    $finish;
  end

endmodule